// File: doc/BRIEF.md
# Ping-Pong Ancillary Word Buffer

This block holds ancillary packet words for a video inserter in a store split into two equal halves. A host write port appends words to one half while a read port hands words from a half to the inserter, one per request, with a valid flag and an end-of-data flag. The host moves the roles of the two halves by flipping one switch bit. The block follows a four-step rotation that first redirects writes, then on the next flip discards the half that has been read and moves reading onto the freshly written half.

Reading rewinds to the start of the read half at every frame start, so the same set of packets can be re-inserted frame after frame until the host switches. Role changes must be spaced by a minimum number of clock cycles. A flip that comes too early is ignored and reported through a sticky flag. Writes into a full half are dropped and reported through a second sticky flag.

Top module: `anc_pingpong_buf`

## Requirements
- R1: After reset, wr_half_o and rd_half_o are 0 (first half), overflow_o and gap_err_o are 0, rd_valid_o and rd_end_o are 0.
- R2: A host write (wr_en_i high on a clock edge) appends wr_data_i after the last word of the half selected by wr_half_o. A read request (rd_en_i high) on a half with unread words returns the next word in write order on rd_data_o with rd_valid_o high in the following cycle; rd_end_o is high together with the last stored word.
- R3: A read request when the read half has no unread words gives rd_valid_o low and rd_end_o high in the following cycle.
- R4: A high frame_start_i moves the read position back to the first word of the read half; a read request in the same cycle returns that first word.
- R5: Each accepted flip of switch_i advances the roles, visible the cycle after the flip is sampled, through the sequence {wr_half_o, rd_half_o} = 00, 10, 11, 01, then back to 00; half index 0 is the first half, 1 the second.
- R6: The flip that moves reading from the first half to the second (10 to 11) empties the first half; the flip from 01 to 00 empties the second half; on each of these the read position restarts at the first word of the new read half.
- R7: A flip of switch_i sampled fewer than MIN_GAP (default 1100) cycles after the previous accepted flip leaves the roles unchanged and sets the sticky gap_err_o; the first flip after reset is always accepted.
- R8: A host write into a half that already holds HALF_DEPTH (default 512) words is dropped and sets the sticky overflow_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Host word write strobe |
| wr_data_i | input | WORD_W | Host word to store |
| switch_i | input | 1 | Role switch bit; every change is a flip |
| frame_start_i | input | 1 | Frame start pulse, rewinds reading |
| rd_en_i | input | 1 | Read request from the inserter |
| rd_data_o | output | WORD_W | Word returned one cycle after a request |
| rd_valid_o | output | 1 | rd_data_o holds a stored word |
| rd_end_o | output | 1 | Last stored word, or nothing left to read |
| wr_half_o | output | 1 | Half receiving host writes |
| rd_half_o | output | 1 | Half being read |
| overflow_o | output | 1 | Sticky: a write into a full half was dropped |
| gap_err_o | output | 1 | Sticky: a flip came before the minimum spacing |

## Verification
A wrong role state shows on wr_half_o and rd_half_o in the cycle after the flip and then on the words the next read pass returns, which come from the wrong half or include words that should have been discarded. A fill count that was not cleared, or a read position that did not restart, shows as stale words or a missing end flag within one read pass after the next frame start. Gap and overflow errors show on their sticky flags in the cycle after the offending flip or write, and a dropped write must leave no trace in the following read pass.

// File: rtl/anc_pp_pkg.sv
package anc_pp_pkg;

  // Role rotation: bit 1 selects the read half, bit1^bit0 the write half.
  typedef enum logic [1:0] {
    PH_SAME0  = 2'b00,
    PH_SPLIT0 = 2'b01,
    PH_SAME1  = 2'b10,
    PH_SPLIT1 = 2'b11
  } pp_phase_e;

  function automatic logic wr_half_of(pp_phase_e p);
    return p[1] ^ p[0];
  endfunction

  function automatic logic rd_half_of(pp_phase_e p);
    return p[1];
  endfunction

endpackage

// File: rtl/anc_pp_switch_ctrl.sv
module anc_pp_switch_ctrl
  import anc_pp_pkg::*;
#(
  parameter int MIN_GAP = 1100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic switch_i,
  output logic wr_half_o,
  output logic rd_half_o,
  output logic clr_en_o,
  output logic clr_half_o,
  output logic gap_err_o
);
  localparam int CW = $clog2(MIN_GAP + 1);

  pp_phase_e      phase_q;
  logic           sw_q;
  logic [CW-1:0]  gap_cnt_q;
  logic           flip, gap_ok, accept;
  logic [1:0]     phase_nxt;

  assign flip      = switch_i ^ sw_q;
  assign gap_ok    = gap_cnt_q >= CW'(MIN_GAP);
  assign accept    = flip & gap_ok;
  assign phase_nxt = phase_q + 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q      <= 1'b0;
      gap_cnt_q <= CW'(MIN_GAP);
      phase_q   <= PH_SAME0;
      gap_err_o <= 1'b0;
    end else begin
      sw_q <= switch_i;
      if (accept) begin
        phase_q   <= pp_phase_e'(phase_nxt);
        gap_cnt_q <= CW'(1);
      end else if (!gap_ok) begin
        gap_cnt_q <= gap_cnt_q + CW'(1);
      end
      if (flip && !gap_ok) gap_err_o <= 1'b1;
    end
  end

  assign wr_half_o  = wr_half_of(phase_q);
  assign rd_half_o  = rd_half_of(phase_q);
  // Leaving a split phase discards the half that was being read.
  assign clr_en_o   = accept & phase_q[0];
  assign clr_half_o = phase_q[1];

endmodule

// File: rtl/anc_pp_fill_track.sv
module anc_pp_fill_track #(
  parameter int HALF_DEPTH = 512,
  localparam int AW = $clog2(HALF_DEPTH),
  localparam int FW = $clog2(HALF_DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_half_i,
  input  logic                clr_en_i,
  input  logic                clr_half_i,
  output logic [1:0][FW-1:0]  fill_o,
  output logic                wr_ok_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic                overflow_o
);
  logic room;

  assign room      = fill_o[wr_half_i] < FW'(HALF_DEPTH);
  assign wr_ok_o   = wr_en_i & room;
  assign wr_addr_o = fill_o[wr_half_i][AW-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fill_o[g] <= '0;
      end else if (clr_en_i && (clr_half_i == 1'(g))) begin
        fill_o[g] <= '0;
      end else if (wr_ok_o && (wr_half_i == 1'(g))) begin
        fill_o[g] <= fill_o[g] + FW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overflow_o <= 1'b0;
    else if (wr_en_i && !room)  overflow_o <= 1'b1;
  end

endmodule

// File: rtl/anc_pp_store.sv
module anc_pp_store #(
  parameter int WORD_W     = 10,
  parameter int HALF_DEPTH = 512,
  localparam int AW    = $clog2(HALF_DEPTH),
  localparam int DEPTH = 2 ** (AW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW:0]       waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW:0]       raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/anc_pp_reader.sv
module anc_pp_reader #(
  parameter int HALF_DEPTH = 512,
  localparam int AW = $clog2(HALF_DEPTH),
  localparam int FW = $clog2(HALF_DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic          frame_start_i,
  input  logic          restart_i,
  input  logic          rd_half_i,
  input  logic [FW-1:0] fill_i,
  output logic          re_o,
  output logic [AW:0]   raddr_o,
  output logic          rd_valid_o,
  output logic          rd_end_o
);
  logic [FW-1:0] ptr_q, ptr_eff;
  logic          is_last;

  assign ptr_eff = frame_start_i ? '0 : ptr_q;
  assign re_o    = rd_en_i && (ptr_eff < fill_i);
  assign raddr_o = {rd_half_i, ptr_eff[AW-1:0]};
  // Wider compare so ptr+1 cannot wrap.
  assign is_last = ({1'b0, ptr_eff} + (FW+1)'(1)) >= {1'b0, fill_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      rd_valid_o <= 1'b0;
      rd_end_o   <= 1'b0;
    end else begin
      if (restart_i)  ptr_q <= '0;
      else if (re_o)  ptr_q <= ptr_eff + FW'(1);
      else            ptr_q <= ptr_eff;
      rd_valid_o <= re_o;
      rd_end_o   <= rd_en_i && is_last;
    end
  end

endmodule

// File: rtl/anc_pingpong_buf.sv
module anc_pingpong_buf #(
  parameter int WORD_W     = 10,
  parameter int HALF_DEPTH = 512,
  parameter int MIN_GAP    = 1100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              switch_i,
  input  logic              frame_start_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              rd_end_o,
  output logic              wr_half_o,
  output logic              rd_half_o,
  output logic              overflow_o,
  output logic              gap_err_o
);
  localparam int AW = $clog2(HALF_DEPTH);
  localparam int FW = $clog2(HALF_DEPTH + 1);

  logic               clr_en, clr_half;
  logic [1:0][FW-1:0] fill;
  logic               wr_ok;
  logic [AW-1:0]      wr_addr;
  logic               re;
  logic [AW:0]        raddr;

  anc_pp_switch_ctrl #(.MIN_GAP(MIN_GAP)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .switch_i   (switch_i),
    .wr_half_o  (wr_half_o),
    .rd_half_o  (rd_half_o),
    .clr_en_o   (clr_en),
    .clr_half_o (clr_half),
    .gap_err_o  (gap_err_o)
  );

  anc_pp_fill_track #(.HALF_DEPTH(HALF_DEPTH)) u_fill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_half_i  (wr_half_o),
    .clr_en_i   (clr_en),
    .clr_half_i (clr_half),
    .fill_o     (fill),
    .wr_ok_o    (wr_ok),
    .wr_addr_o  (wr_addr),
    .overflow_o (overflow_o)
  );

  anc_pp_store #(.WORD_W(WORD_W), .HALF_DEPTH(HALF_DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok),
    .waddr_i ({wr_half_o, wr_addr}),
    .wdata_i (wr_data_i),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rd_data_o)
  );

  anc_pp_reader #(.HALF_DEPTH(HALF_DEPTH)) u_reader (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rd_en_i       (rd_en_i),
    .frame_start_i (frame_start_i),
    .restart_i     (clr_en),
    .rd_half_i     (rd_half_o),
    .fill_i        (fill[rd_half_o]),
    .re_o          (re),
    .raddr_o       (raddr),
    .rd_valid_o    (rd_valid_o),
    .rd_end_o      (rd_end_o)
  );

endmodule

// File: rtl/anc_pingpong_buf_chk.sv
module anc_pingpong_buf_chk #(
  parameter int MIN_GAP = 1100
) (
  input logic clk_i,
  input logic rst_ni,
  input logic rd_en_i,
  input logic rd_valid_o,
  input logic rd_end_o,
  input logic wr_half_o,
  input logic rd_half_o,
  input logic overflow_o,
  input logic gap_err_o
);
  localparam int CW = $clog2(MIN_GAP + 1);

  logic [1:0]    roles, roles_q;
  logic [CW-1:0] since_q;
  logic          moved;

  assign roles = {wr_half_o, rd_half_o};
  assign moved = roles != roles_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      roles_q <= 2'b00;
      since_q <= CW'(MIN_GAP);
    end else begin
      roles_q <= roles;
      if (moved)                       since_q <= CW'(1);
      else if (since_q < CW'(MIN_GAP)) since_q <= since_q + CW'(1);
    end
  end

  // R5
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(roles ^ roles_q) <= 1);

  // R7
  gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moved |-> since_q >= CW'(MIN_GAP));

  // R7
  gap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_err_o |=> gap_err_o);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  // R2
  valid_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_valid_o) |-> $past(rd_en_i));

  // R3
  end_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_end_o) |-> $past(rd_en_i));

endmodule

bind anc_pingpong_buf anc_pingpong_buf_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_end_o   (rd_end_o),
  .wr_half_o  (wr_half_o),
  .rd_half_o  (rd_half_o),
  .overflow_o (overflow_o),
  .gap_err_o  (gap_err_o)
);

// File: tb/anc_pingpong_buf_bench.sv
module anc_pingpong_buf_bench;
  localparam int WORD_W     = 10;
  localparam int HALF_DEPTH = 16;
  localparam int MIN_GAP    = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [WORD_W-1:0] wr_data = '0;
  logic              sw = 1'b0;
  logic              frame_start = 1'b0;
  logic              rd_en = 1'b0;
  logic [WORD_W-1:0] rd_data;
  logic              rd_valid, rd_end, wr_half, rd_half, overflow, gap_err;

  int checks = 0;
  int failures = 0;

  logic [WORD_W-1:0] exp_d[$];
  bit                exp_last[$];
  string             exp_req[$];

  always #10 clk = ~clk;

  anc_pingpong_buf #(.WORD_W(WORD_W), .HALF_DEPTH(HALF_DEPTH), .MIN_GAP(MIN_GAP))
  u_anc_pingpong_buf (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .switch_i(sw), .frame_start_i(frame_start), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_end_o(rd_end),
    .wr_half_o(wr_half), .rd_half_o(rd_half),
    .overflow_o(overflow), .gap_err_o(gap_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops scoreboard entries as words come out.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_d.size() == 0) begin
        check(1'b0, "R2 unexpected word", int'(rd_data), 0);
      end else begin
        logic [WORD_W-1:0] d;
        bit l;
        string r;
        d = exp_d.pop_front();
        l = exp_last.pop_front();
        r = exp_req.pop_front();
        check(rd_data == d, {r, " data"}, int'(rd_data), int'(d));
        check(rd_end == l, {r, " end flag"}, int'(rd_end), int'(l));
      end
    end
  end

  task automatic write_word(input logic [WORD_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_expect(input logic [WORD_W-1:0] d, input bit last, input string req);
    exp_d.push_back(d); exp_last.push_back(last); exp_req.push_back(req);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic read_empty(input string req);
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check(rd_valid == 1'b0, {req, " valid on empty"}, int'(rd_valid), 0);
    check(rd_end == 1'b1, {req, " end on empty"}, int'(rd_end), 1);
  endtask

  task automatic frame_pulse();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic flip();
    @(negedge clk); sw = ~sw;
    @(negedge clk);
  endtask

  task automatic wait_gap();
    repeat (MIN_GAP) @(negedge clk);
  endtask

  task automatic roles_is(input logic [1:0] exp, input string req);
    check({wr_half, rd_half} == exp, {req, " roles"}, int'({wr_half, rd_half}), int'(exp));
  endtask

  task automatic drained(input string req);
    @(negedge clk);
    check(exp_d.size() == 0, {req, " pending words"}, exp_d.size(), 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rd_valid == 0 && rd_end == 0, "R1 read outputs", int'({rd_valid, rd_end}), 0);
    check(overflow == 0 && gap_err == 0, "R1 flags", int'({overflow, gap_err}), 0);
    roles_is(2'b00, "R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 append and read in order
    write_word(10'h011); write_word(10'h022); write_word(10'h033);
    read_expect(10'h011, 0, "R2"); read_expect(10'h022, 0, "R2"); read_expect(10'h033, 1, "R2");
    drained("R2");
    read_empty("R3");

    // R4 rewind
    frame_pulse();
    read_expect(10'h011, 0, "R4"); read_expect(10'h022, 0, "R4"); read_expect(10'h033, 1, "R4");
    drained("R4");
    // R4 read in the frame-start cycle returns the first word
    exp_d.push_back(10'h011); exp_last.push_back(0); exp_req.push_back("R4 same cycle");
    @(negedge clk); frame_start = 1'b1; rd_en = 1'b1;
    @(negedge clk); frame_start = 1'b0; rd_en = 1'b0;
    drained("R4");

    // R5 first flip: writes to half 1, reading stays on half 0
    flip(); roles_is(2'b10, "R5 flip1");
    write_word(10'h101); write_word(10'h102);
    frame_pulse();
    read_expect(10'h011, 0, "R5"); read_expect(10'h022, 0, "R5"); read_expect(10'h033, 1, "R5");
    drained("R5");

    // R5/R6 second flip: read half 1 from its first word
    wait_gap();
    flip(); roles_is(2'b11, "R5 flip2");
    read_expect(10'h101, 0, "R6"); read_expect(10'h102, 1, "R6");
    write_word(10'h103);
    read_expect(10'h103, 1, "R6");
    drained("R6");

    // R7 early flip ignored
    flip();
    check(gap_err == 1'b1, "R7 gap flag", int'(gap_err), 1);
    roles_is(2'b11, "R7 ignored");

    // R5 third flip: writes to half 0 (cleared), reading stays on half 1
    wait_gap();
    flip(); roles_is(2'b01, "R5 flip3");
    write_word(10'h2D0);
    frame_pulse();
    read_expect(10'h101, 0, "R5"); read_expect(10'h102, 0, "R5"); read_expect(10'h103, 1, "R5");
    drained("R5");

    // R6 fourth flip: half 0 holds only the word written after it was emptied
    wait_gap();
    flip(); roles_is(2'b00, "R5 flip4");
    read_expect(10'h2D0, 1, "R6 half0 cleared");
    drained("R6");

    // R8 fill half 0, then two dropped writes
    for (int i = 1; i < HALF_DEPTH; i++) write_word(WORD_W'(10'h100 + i));
    check(overflow == 1'b0, "R8 no overflow at full", int'(overflow), 0);
    write_word(10'h3EE); write_word(10'h3FF);
    check(overflow == 1'b1, "R8 overflow flag", int'(overflow), 1);
    frame_pulse();
    read_expect(10'h2D0, 0, "R8");
    for (int i = 1; i < HALF_DEPTH; i++)
      read_expect(WORD_W'(10'h100 + i), i == HALF_DEPTH - 1, "R8");
    drained("R8");
    read_empty("R8 dropped words absent");

    // R6 half 1 was emptied by the fourth flip
    wait_gap();
    flip(); roles_is(2'b10, "R5 flip5");
    write_word(10'h3AB);
    wait_gap();
    flip(); roles_is(2'b11, "R5 flip6");
    read_expect(10'h3AB, 1, "R6 half1 cleared");
    drained("R6");
    read_empty("R6");

    check(gap_err == 1'b1 && overflow == 1'b1, "R7 R8 sticky", int'({gap_err, overflow}), 3);
    finish_run();
  end

endmodule